// File: doc/BRIEF.md
# NRZI Framed Serial Transmitter with Zero-Run Stuffing

This block turns a stream of 16-bit words into a single-wire serial line. It sends one logical bit every second clock cycle, so a 40 MHz clock yields a 20 Mbit/s line. A logical one becomes a change of line level and a logical zero leaves the level unchanged. A frame opens with three ones as a sync pattern. A 16-bit header word follows, with the packet type in its upper byte and the payload length, counted in words, in its lower byte. The payload words come last. Every word goes out most significant bit first.

Between frames the line carries logical zeros. A stuffing stage watches the outgoing logical stream. After six zeros in a row it inserts a one, so the line never stays flat for long. On an idle link this toggles the line every seven bit times. While the inserted one is on the line, the sequencer holds its current bit and sends it one bit time later. No payload bit is lost.

Words enter through a valid/ready handshake with a start-of-frame flag. The sequencer has five states. SEQ_IDLE sends zeros and waits for a flagged header word. SEQ_SYNC sends the three sync ones. SEQ_HDR shifts out the header. SEQ_DATA shifts out a payload word. SEQ_GAP sends zeros while a payload word is due but not yet offered.

The transitions are:
- IDLE to SYNC when a flagged word is taken.
- SYNC to HDR after the third sync bit.
- HDR or DATA to IDLE after the last bit of a word when no words remain.
- HDR or DATA to DATA when the next word is taken on that last bit.
- HDR or DATA to GAP when the next word is due but not offered.
- GAP to DATA when a word is taken.

Top module: `nrzi_frame_tx`

## Requirements
- R1: The line level can change only on a bit boundary. Bit boundaries fall every CLK_PER_BIT cycles: after reset, on the 2nd, 4th, 6th, ... rising edge.
- R2: On each bit boundary the line toggles when the logical bit is 1 and holds when it is 0.
- R3: After six consecutive logical zeros, the next logical bit is always 1. The zero-run count restarts after any logical one, whether it is a sync, header, data or inserted bit.
- R4: An inserted one delays the sequencer's stream by one bit time and drops no bit. The receiver recovers every word intact once it removes each one that follows six zeros.
- R5: A frame is the bits 1,1,1, then the header word MSB first. The header holds the type in bits 15:8 and the length in bits 7:0.
- R6: After the header, exactly the number of words given in the length field are sent, each MSB first. A length of 0 gives a header-only frame. The sequencer then returns to idle.
- R7: While idle, the logical stream is all zeros. After reset, with nothing offered, the line first toggles on rising edge 14 and again on edge 28.
- R8: In reset, line_out is 0 and in_ready is 0.
- R9: in_ready is high only in the cycle before a bit boundary. It is low when that boundary carries an inserted one, and low while a word or the sync pattern still has bits to send.
- R10: A word offered in idle without the start flag is consumed and discarded, and no frame is sent. Words taken during a frame are payload whatever their flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate reference clock, two cycles per line bit |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream word is offered |
| in_ready | output | 1 | Word is taken at this rising edge if in_valid is high |
| in_sof | input | 1 | Offered word is a frame header |
| in_data | input | 16 | Header or payload word |
| line_out | output | 1 | NRZI-coded serial line |

## Verification
The bench builds the block with its default parameters: 16-bit words, an 8-bit length field, three sync bits, a six-zero stuffing limit and two cycles per bit. These values keep a full sweep small. Every payload length from 0 to 5 is combined with three header types, using all-zero, all-one, sparse and mixed words. This covers stuffing inside headers, inside payload and across word joins.

A receiver in the bench decodes the line, strips the inserted ones and parses frames. With the default stuffing limit, the idle toggle period of 14 cycles and the exact handshake windows can be predicted and checked cycle by cycle.

// File: rtl/nrzi_tx_pkg.sv
package nrzi_tx_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_SYNC,
        SEQ_HDR,
        SEQ_DATA,
        SEQ_GAP
    } seq_state_t;

endpackage

// File: rtl/bit_timer.sv
module bit_timer #(
    parameter int CLK_PER_BIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    generate
        if (CLK_PER_BIT > 1) begin : g_div
            localparam int DW = $clog2(CLK_PER_BIT);
            localparam logic [DW-1:0] LAST = DW'(CLK_PER_BIT - 1);

            logic [DW-1:0] phase;

            always_ff @(posedge clk) begin
                if (!rst_n)
                    phase <= '0;
                else if (phase == LAST)
                    phase <= '0;
                else
                    phase <= phase + 1'b1;
            end

            assign tick = (phase == LAST);

            AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n) // R1
                tick |=> !tick);
        end else begin : g_full
            assign tick = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/frame_seq.sv
module frame_seq
    import nrzi_tx_pkg::*;
#(
    parameter int WORD_W   = 16,
    parameter int LEN_W    = 8,
    parameter int SYNC_LEN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    output logic              seq_bit
);

    localparam int CNT_W = $clog2(WORD_W > SYNC_LEN ? WORD_W : SYNC_LEN);
    localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] SYNC_LAST = CNT_W'(SYNC_LEN - 1);

    seq_state_t        state, state_n;
    logic [WORD_W-1:0] sh, sh_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic [LEN_W-1:0]  rem, rem_n;
    logic              in_word, word_end, fetch_pt, take;

    assign in_word  = (state == SEQ_HDR) || (state == SEQ_DATA);
    assign word_end = in_word && (cnt == WORD_LAST);
    assign fetch_pt = word_end && (rem != '0);
    assign take     = in_ready && in_valid;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            sh    <= '0;
            cnt   <= '0;
            rem   <= '0;
        end else begin
            state <= state_n;
            sh    <= sh_n;
            cnt   <= cnt_n;
            rem   <= rem_n;
        end
    end

    // next state
    always_comb begin
        state_n = state;
        sh_n    = sh;
        cnt_n   = cnt;
        rem_n   = rem;
        unique case (state)
            SEQ_IDLE: begin
                if (take && in_sof) begin
                    state_n = SEQ_SYNC;
                    sh_n    = in_data;
                    rem_n   = in_data[LEN_W-1:0];
                    cnt_n   = '0;
                end
            end
            SEQ_SYNC: begin
                if (adv) begin
                    if (cnt == SYNC_LAST) begin
                        state_n = SEQ_HDR;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            SEQ_HDR, SEQ_DATA: begin
                if (adv) begin
                    if (cnt == WORD_LAST) begin
                        cnt_n = '0;
                        if (rem == '0) begin
                            state_n = SEQ_IDLE;
                        end else if (take) begin
                            state_n = SEQ_DATA;
                            sh_n    = in_data;
                            rem_n   = rem - 1'b1;
                        end else begin
                            state_n = SEQ_GAP;
                        end
                    end else begin
                        sh_n  = {sh[WORD_W-2:0], 1'b0};
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            SEQ_GAP: begin
                if (take) begin
                    state_n = SEQ_DATA;
                    sh_n    = in_data;
                    rem_n   = rem - 1'b1;
                    cnt_n   = '0;
                end
            end
            default: state_n = SEQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_ready = 1'b0;
        seq_bit  = 1'b0;
        unique case (state)
            SEQ_IDLE:           in_ready = adv;
            SEQ_GAP:            in_ready = adv;
            SEQ_SYNC:           seq_bit  = 1'b1;
            SEQ_HDR, SEQ_DATA: begin
                seq_bit  = sh[WORD_W-1];
                in_ready = adv && fetch_pt;
            end
            default: begin
                in_ready = 1'b0;
                seq_bit  = 1'b0;
            end
        endcase
    end

    AST_SYNC_TO_HDR: assert property (@(posedge clk) disable iff (!rst_n) // R5
        (adv && state == SEQ_SYNC && cnt == SYNC_LAST) |=> state == SEQ_HDR);

    AST_LEN_ZERO_END: assert property (@(posedge clk) disable iff (!rst_n) // R6
        (adv && word_end && rem == '0) |=> state == SEQ_IDLE);

    AST_NO_READY_MIDWORD: assert property (@(posedge clk) disable iff (!rst_n) // R9
        (in_word && cnt != WORD_LAST) |-> !in_ready);

endmodule

// File: rtl/zero_stuffer.sv
module zero_stuffer #(
    parameter int ZERO_RUN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic seq_bit,
    output logic adv,
    output logic line_bit
);

    localparam int RUN_W = $clog2(ZERO_RUN + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(ZERO_RUN);

    logic [RUN_W-1:0] run;
    logic             stuff;

    assign stuff    = (run == RUN_MAX);
    assign adv      = tick && !stuff;
    assign line_bit = stuff || seq_bit;

    always_ff @(posedge clk) begin
        if (!rst_n)
            run <= '0;
        else if (tick)
            run <= line_bit ? '0 : run + 1'b1;
    end

    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n) // R3
        run <= RUN_MAX);

    AST_RUN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) // R3
        (tick && run == RUN_MAX) |=> run == '0);

endmodule

// File: rtl/nrzi_enc.sv
module nrzi_enc #(
    parameter logic INIT_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic line_bit,
    output logic line_out
);

    always_ff @(posedge clk) begin
        if (!rst_n)
            line_out <= INIT_LEVEL;
        else if (tick)
            line_out <= line_out ^ line_bit;
    end

    AST_ONE_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n) // R2
        (tick && line_bit) |=> line_out != $past(line_out));

    AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) // R2
        (tick && !line_bit) |=> $stable(line_out));

endmodule

// File: rtl/nrzi_frame_tx.sv
module nrzi_frame_tx #(
    parameter int   WORD_W      = 16,
    parameter int   LEN_W       = 8,
    parameter int   SYNC_LEN    = 3,
    parameter int   ZERO_RUN    = 6,
    parameter int   CLK_PER_BIT = 2,
    parameter logic INIT_LEVEL  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_sof,
    input  logic [WORD_W-1:0] in_data,
    output logic              line_out
);

    logic tick, adv, seq_bit, line_bit;

    bit_timer #(.CLK_PER_BIT(CLK_PER_BIT)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    frame_seq #(.WORD_W(WORD_W), .LEN_W(LEN_W), .SYNC_LEN(SYNC_LEN)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .in_data  (in_data),
        .in_ready (in_ready),
        .seq_bit  (seq_bit)
    );

    zero_stuffer #(.ZERO_RUN(ZERO_RUN)) u_stuff (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .seq_bit  (seq_bit),
        .adv      (adv),
        .line_bit (line_bit)
    );

    nrzi_enc #(.INIT_LEVEL(INIT_LEVEL)) u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .line_bit (line_bit),
        .line_out (line_out)
    );

    AST_READY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n) // R9
        in_ready |-> tick);

    AST_LINE_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n) // R1
        !tick |=> $stable(line_out));

endmodule

// File: tb/nrzi_frame_tx_test.sv
module nrzi_frame_tx_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sof = 1'b0;
    logic [15:0] in_data = '0;
    logic        in_ready;
    logic        line_out;

    always #10 clk = ~clk;

    nrzi_frame_tx uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_sof   (in_sof),
        .in_data  (in_data),
        .line_out (line_out)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expected word list
    logic [15:0] exp_w [0:255];
    string       exp_tag [0:255];
    int          exp_n = 0;

    // edge counter since reset release
    int edge_n = 0;
    always @(posedge clk) begin
        if (!rst_n) edge_n <= 0;
        else        edge_n <= edge_n + 1;
    end

    // receiver state
    logic        prev_line = 1'b0;
    int          zrun = 0;
    int          pst = 0;       // 0 idle, 1 sync, 2 word
    int          sync_n = 0;
    int          wbits = 0;
    logic [15:0] wacc = '0;
    bit          is_hdr = 0;
    int          remw = 0;
    int          rx_idx = 0;
    int          syncs_seen = 0;
    int          tog_cnt = 0;
    int          tog_edge [0:1];
    int          last_change = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            // R9 handshake window checks
            if (in_ready) begin
                chk((edge_n % 2) == 1, "R9 ready off boundary", edge_n, 1);
                chk(zrun != 6, "R9 ready during inserted one", zrun, 0);
                chk(!(pst == 1 || (pst == 2 && wbits < 15)), "R9 ready mid-word", wbits, 15);
            end
            // R1 line changes only on even edges
            if (line_out != prev_line && (edge_n % 2) == 1)
                chk(1'b0, "R1 change off boundary", edge_n, edge_n + 1);
            if (edge_n > 0 && (edge_n % 2) == 0) begin
                logic b;
                b = line_out ^ prev_line;
                prev_line = line_out;
                if (b && tog_cnt < 2) begin
                    tog_edge[tog_cnt] = edge_n;
                    tog_cnt++;
                end
                if (zrun == 6) begin
                    chk(b == 1'b1, "R3 one after six zeros", b, 1);
                    zrun = 0;
                end else begin
                    zrun = b ? 0 : zrun + 1;
                    case (pst)
                        0: if (b) begin
                            pst = 1;
                            sync_n = 1;
                            syncs_seen++;
                        end
                        1: begin
                            if (b) begin
                                sync_n++;
                                if (sync_n == 3) begin
                                    pst = 2;
                                    is_hdr = 1;
                                    wbits = 0;
                                end
                            end else begin
                                chk(1'b0, "R5 sync pattern", sync_n, 3);
                                pst = 0;
                            end
                        end
                        default: begin
                            wacc = {wacc[14:0], b};
                            wbits++;
                            if (wbits == 16) begin
                                wbits = 0;
                                if (rx_idx < exp_n)
                                    chk(wacc == exp_w[rx_idx], exp_tag[rx_idx], wacc, exp_w[rx_idx]);
                                else
                                    chk(1'b0, "R6 extra word", wacc, 0);
                                rx_idx++;
                                if (is_hdr) begin
                                    is_hdr = 0;
                                    remw = int'(wacc[7:0]);
                                end else begin
                                    remw--;
                                end
                                if (remw == 0) pst = 0;
                            end
                        end
                    endcase
                end
            end
        end
    end

    task automatic send_word(input logic [15:0] d, input logic s);
        in_valid = 1'b1;
        in_data  = d;
        in_sof   = s;
        do @(negedge clk); while (!in_ready);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic logic [15:0] pat(input int f, input int j);
        case ((f + j) % 4)
            0: pat = 16'h0000;
            1: pat = 16'hFFFF;
            2: pat = 16'h8001;
            default: pat = 16'(f * 16'h1357 + j * 16'h0F0F);
        endcase
    endfunction

    initial begin
        logic [7:0] types [0:2];
        types[0] = 8'h00;
        types[1] = 8'hA5;
        types[2] = 8'hFF;

        repeat (3) @(negedge clk);
        chk(line_out == 1'b0, "R8 line in reset", line_out, 0);
        chk(in_ready == 1'b0, "R8 ready in reset", in_ready, 0);
        rst_n = 1'b1;

        // idle toggling
        while (edge_n < 31) @(negedge clk);
        chk(tog_cnt == 2, "R7 two idle toggles", tog_cnt, 2);
        chk(tog_edge[0] == 14, "R7 R2 first idle toggle", tog_edge[0], 14);
        chk(tog_edge[1] == 28, "R7 R3 second idle toggle", tog_edge[1], 28);

        // unflagged word in idle is discarded
        send_word(16'hE703, 1'b0);
        repeat (60) @(negedge clk);
        chk(syncs_seen == 0, "R10 no frame from unflagged word", syncs_seen, 0);
        chk(rx_idx == 0, "R10 no words received", rx_idx, 0);

        // sweep: lengths 0..5 by three types
        for (int f = 0; f < 18; f++) begin
            int len;
            logic [15:0] hdr;
            len = f % 6;
            hdr = {types[f / 6], 8'(len)};
            exp_w[exp_n] = hdr;
            exp_tag[exp_n] = "R5 header";
            exp_n++;
            for (int j = 0; j < len; j++) begin
                exp_w[exp_n] = pat(f, j);
                exp_tag[exp_n] = (f == 7 && j == 0) ? "R10 flagged payload" : "R4 R6 payload";
                exp_n++;
            end
            send_word(hdr, 1'b1);
            for (int j = 0; j < len; j++)
                send_word(pat(f, j), (f == 7 && j == 0));
        end

        while (rx_idx < exp_n) @(negedge clk);
        repeat (80) @(negedge clk);
        chk(rx_idx == exp_n, "R6 word count", rx_idx, exp_n);
        chk(pst == 0, "R6 back to idle", pst, 0);
        chk(syncs_seen == 18, "R6 frame count", syncs_seen, 18);

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R6 actual=%0d expected=%0d", rx_idx, exp_n);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule